// File: doc/BRIEF.md
# Configurable-Format UART Frame Receiver

This block turns an asynchronous serial bit stream on one input line into characters. The format is chosen at run time and must match the paired transmitter:
- the data length, from 5 to 9 bits;
- the parity mode: none, even or odd.

The line is sampled with a 16x oversampling tick that comes from outside, from a baud generator that is not part of this block.

A character is detected when the idle-high line falls and the low level is still present at mid-bit. Every later bit is taken as the majority of three samples around its middle. The received character and its two status flags go into a single holding register: one flag marks a bad stop bit and the other a parity mismatch. A full flag is set when the register is loaded and is cleared when the host pulses a read strobe. Only the first stop bit is examined. A second stop bit, when the transmitter is set to send one, is neither required nor checked, so the stop-bit count is not an input of this block.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, rx_full, frame_err and parity_err are 0, rx_data is 0, and the receiver waits in idle for a falling edge.
- R2: cfg_len selects the data length as 5 + cfg_len for codes 0 to 4; codes 5 to 7 select 9 bits. Data arrives least significant bit first. rx_data[i] holds the i-th received data bit, and rx_data bits at or above the length are 0.
- R3: cfg_parity[1] = 0 means no parity bit, and parity_err is then 0. 2'b10 selects even parity and 2'b11 selects odd parity. The expected parity bit is the XOR of all data bits, inverted for odd parity. parity_err is 1 exactly when the received parity bit differs from the expected one.
- R4: When parity is enabled, the parity bit is the bit slot right after the last data bit and before the stop bit.
- R5: frame_err is 1 exactly when the first stop bit is sampled low. The character is still delivered in that case.
- R6: Only the first stop bit is sampled. The character is delivered before the middle of that stop bit has passed by more than two oversampling ticks. A new start bit may follow directly after one stop bit.
- R7: A falling edge starts a frame only if the majority of the mid-bit samples of the start bit is low. Otherwise the receiver returns to idle and delivers no character.
- R8: Each bit value is the majority of the samples at oversampling ticks 7, 8 and 9 of the bit, so a glitch that touches one sample does not change the bit.
- R9: rx_full goes to 1 in the cycle after a character completes, and goes to 0 in the cycle after a rd_strobe pulse. If a character completes in the same cycle as the pulse, the completion wins.
- R10: rx_data, frame_err and parity_err change only when a new character is loaded. A read leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high, not synchronized |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 3 | Data length code (R2) |
| cfg_parity | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| rd_strobe | input | 1 | Host read pulse, clears rx_full |
| rx_data | output | 9 | Last received character, right-aligned |
| rx_full | output | 1 | Unread character held |
| frame_err | output | 1 | First stop bit of the held character was low |
| parity_err | output | 1 | Parity of the held character mismatched |

## Verification
The bench sweeps every 5-bit value under all three parity modes, and walks patterns through the other lengths, including the all-ones word. A design that took data MSB first, took the wrong number of bits, or looked for parity in the wrong slot would return shifted data or false parity errors. Frames with an inverted parity bit or a low stop bit must raise exactly the matching flag. Two frames sent back to back with one stop bit, and reads taken in the middle of a stop bit, expose a receiver that waits for a second stop bit. A short low pulse on the idle line and a one-cycle spike inside a data bit show whether the start check and the three-sample vote are present: without them the receiver would deliver a phantom character or a flipped bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_MIN = 5;
  localparam int DATA_MAX = 9;
  localparam int NB_W     = $clog2(DATA_MAX + 1);
  localparam int LEN_W    = 3;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;

  // number of data bits selected by a length code
  function automatic logic [NB_W-1:0] data_bits(input logic [LEN_W-1:0] code);
    if (code > LEN_W'(DATA_MAX - DATA_MIN)) return NB_W'(DATA_MAX);
    return NB_W'(code) + NB_W'(DATA_MIN);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // parity bit a transmitter would send for this word
  function automatic logic calc_par(input logic [DATA_MAX-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // right-align a word that was shifted in from the top
  function automatic logic [DATA_MAX-1:0] align_word(input logic [DATA_MAX-1:0] sh,
                                                     input logic [NB_W-1:0] nb);
    return sh >> (NB_W'(DATA_MAX) - nb);
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d_in};
  end

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_s,
  input  logic                 os_tick,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic [1:0]           cfg_parity,
  output logic                 start_seen,
  output logic                 start_reject,
  output logic                 frame_done,
  output logic                 busy,
  output logic [DATA_MAX-1:0]  word_out,
  output logic                 fe_out,
  output logic                 pe_out
);
  localparam int CW = $clog2(OS_RATE);
  localparam int MID = OS_RATE / 2;
  localparam logic [CW-1:0] T_A   = CW'(MID - 1);
  localparam logic [CW-1:0] T_B   = CW'(MID);
  localparam logic [CW-1:0] T_V   = CW'(MID + 1);
  localparam logic [CW-1:0] T_END = CW'(OS_RATE - 1);

  rx_state_t            st;
  logic [CW-1:0]        cnt;
  logic                 s_a, s_b, rx_prev, par_rx;
  logic [NB_W-1:0]      idx;
  logic [DATA_MAX-1:0]  sh;

  logic [NB_W-1:0] nb;
  logic            par_en, vote_now, vote_val, bit_end;

  assign nb       = data_bits(cfg_len);
  assign par_en   = cfg_parity[1];
  assign busy     = (st != RX_IDLE);
  assign vote_now = busy && os_tick && (cnt == T_V);
  assign bit_end  = busy && os_tick && (cnt == T_END);
  assign vote_val = maj3(s_a, s_b, rx_s);

  assign start_seen   = (st == RX_IDLE) && rx_prev && !rx_s;
  assign start_reject = (st == RX_START) && vote_now && vote_val;
  assign frame_done   = (st == RX_STOP) && vote_now;

  assign word_out = align_word(sh, nb);
  assign fe_out   = !vote_val;
  assign pe_out   = par_en && (par_rx != calc_par(word_out, cfg_parity[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; s_a <= 1'b1; s_b <= 1'b1;
      rx_prev <= 1'b1; par_rx <= 1'b0; idx <= '0; sh <= '0;
    end else begin
      rx_prev <= rx_s;
      if (start_seen)          cnt <= '0;
      else if (busy && os_tick) cnt <= cnt + 1'b1;
      if (os_tick && cnt == T_A) s_a <= rx_s;
      if (os_tick && cnt == T_B) s_b <= rx_s;
      case (st)
        RX_IDLE:  if (start_seen) st <= RX_START;
        RX_START: begin
          if (start_reject) st <= RX_IDLE;
          else if (bit_end) begin st <= RX_DATA; idx <= '0; end
        end
        RX_DATA: begin
          if (vote_now) sh <= {vote_val, sh[DATA_MAX-1:1]};
          if (bit_end) begin
            if (idx == nb - 1'b1) st <= par_en ? RX_PAR : RX_STOP;
            else                  idx <= idx + 1'b1;
          end
        end
        RX_PAR: begin
          if (vote_now) par_rx <= vote_val;
          if (bit_end)  st <= RX_STOP;
        end
        RX_STOP:  if (vote_now) st <= RX_IDLE;
        default:  st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                rd,
  input  logic [DATA_MAX-1:0] d_in,
  input  logic                fe_in,
  input  logic                pe_in,
  output logic [DATA_MAX-1:0] d_out,
  output logic                full,
  output logic                fe,
  output logic                pe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= '0; full <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else if (load) begin
      d_out <= d_in; full <= 1'b1; fe <= fe_in; pe <= pe_in;
    end else if (rd) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                os_tick,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                rd_strobe,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_full,
  output logic                frame_err,
  output logic                parity_err
);
  logic rx_s, start_seen, start_reject, frame_done, busy, fe_w, pe_w;
  logic [DATA_MAX-1:0] word_w;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(rx_line), .d_out(rx_s)
  );

  rx_frame_core #(.OS_RATE(OS_RATE)) core_i (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .start_seen(start_seen), .start_reject(start_reject),
    .frame_done(frame_done), .busy(busy),
    .word_out(word_w), .fe_out(fe_w), .pe_out(pe_w)
  );

  rx_hold_reg hold_i (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .rd(rd_strobe),
    .d_in(word_w), .fe_in(fe_w), .pe_in(pe_w),
    .d_out(rx_data), .full(rx_full), .fe(frame_err), .pe(parity_err)
  );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
  import uart_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rd_strobe,
  input logic [LEN_W-1:0]    cfg_len,
  input logic [1:0]          cfg_parity,
  input logic                start_seen,
  input logic                start_reject,
  input logic                frame_done,
  input logic                busy,
  input logic [DATA_MAX-1:0] rx_data,
  input logic                rx_full,
  input logic                frame_err,
  input logic                parity_err
);
  // R9
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full);
  // R9
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> !rx_full);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));
  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ((rx_data >> data_bits($past(cfg_len))) == '0));
  // R3
  no_parity_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cfg_parity[1]) |=> !parity_err);
  // R7
  reject_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !busy);
  // R7
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy);
endmodule

bind uart_frame_rx uart_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .cfg_len(cfg_len),
  .cfg_parity(cfg_parity), .start_seen(start_seen), .start_reject(start_reject),
  .frame_done(frame_done), .busy(busy), .rx_data(rx_data), .rx_full(rx_full),
  .frame_err(frame_err), .parity_err(parity_err)
);

// File: tb/uart_frame_rx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_rx_tb_top;
  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b0, rd_strobe = 1'b0;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_parity = 2'b00;
  logic [8:0] rx_data;
  logic rx_full, frame_err, parity_err;

  int checks = 0, errors = 0;
  bit done = 0;

  uart_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
    .parity_err(parity_err)
  );

  always @(negedge clk) os_tick <= ~os_tick;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit: data index that gets a one-clock spike, -1 for none
  task automatic send_frame(input int nb, input logic [1:0] pm, input logic [8:0] d,
                            input bit bad_par, input bit bad_stop,
                            input int glitch_bit, input bit mid_check);
    logic p;
    rx_line = 1'b0; wait_clk(BITCLK);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      if (glitch_bit == i) begin
        wait_clk(17); rx_line = ~d[i]; wait_clk(1); rx_line = d[i]; wait_clk(BITCLK - 18);
      end else wait_clk(BITCLK);
    end
    if (pm[1]) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      p = p ^ pm[0] ^ bad_par;
      rx_line = p; wait_clk(BITCLK);
    end
    rx_line = !bad_stop;
    if (mid_check) begin
      wait_clk(28);
      chk(rx_full === 1'b1, "R6", "full before end of first stop", rx_full, 1);
      wait_clk(BITCLK - 28);
    end else wait_clk(BITCLK);
    rx_line = 1'b1;
  endtask

  task automatic expect_char(input int nb, input logic [1:0] pm, input logic [8:0] d,
                             input bit bad_par, input bit bad_stop);
    logic [8:0] exp_d;
    logic [8:0] held;
    logic hf, hp;
    exp_d = d & 9'((1 << nb) - 1);
    chk(rx_full === 1'b1, "R9", "full after frame", rx_full, 1);
    chk(rx_data === exp_d, "R2", "data", rx_data, exp_d);
    chk(frame_err === bad_stop, "R5", "frame_err", frame_err, bad_stop);
    chk(parity_err === (pm[1] & bad_par), "R3 R4", "parity_err", parity_err, pm[1] & bad_par);
    held = rx_data; hf = frame_err; hp = parity_err;
    rd_strobe = 1'b1; wait_clk(1); rd_strobe = 1'b0;
    chk(rx_full === 1'b0, "R9", "full after read", rx_full, 0);
    chk({rx_data, frame_err, parity_err} === {held, hf, hp}, "R10", "held after read",
        {rx_data, frame_err, parity_err}, {held, hf, hp});
  endtask

  task automatic frame_and_check(input logic [2:0] lc, input logic [1:0] pm, input logic [8:0] d,
                                 input bit bad_par, input bit bad_stop, input int glitch_bit);
    int nb;
    nb = (lc > 3'd4) ? 9 : int'(lc) + 5;
    cfg_len = lc; cfg_parity = pm;
    send_frame(nb, pm, d, bad_par, bad_stop, glitch_bit, 1'b0);
    wait_clk(4);
    expect_char(nb, pm, d, bad_par, bad_stop);
  endtask

  initial begin
    wait_clk(5);
    // R1
    chk({rx_full, frame_err, parity_err} === 3'b000, "R1", "flags in reset",
        {rx_full, frame_err, parity_err}, 0);
    chk(rx_data === 9'd0, "R1", "data in reset", rx_data, 0);
    rst_n = 1'b1; wait_clk(6);
    chk(rx_full === 1'b0, "R1", "idle after reset", rx_full, 0);

    // R7: short low pulse on the line is not a start bit
    rx_line = 1'b0; wait_clk(4); rx_line = 1'b1; wait_clk(3 * BITCLK);
    chk(rx_full === 1'b0, "R7", "no char from glitch", rx_full, 0);

    // main sweep: R2 R3 R4 R5
    for (int lc = 0; lc < 5; lc++) begin
      for (int pi = 0; pi < 3; pi++) begin
        logic [1:0] pm;
        int npat;
        int mask;
        pm = (pi == 0) ? 2'b00 : (pi == 1) ? 2'b10 : 2'b11;
        npat = (lc == 0) ? 32 : 8;
        mask = (1 << (lc + 5)) - 1;
        for (int k = 0; k < npat; k++) begin
          logic [8:0] d;
          if (lc == 0) d = 9'(k);
          else if (k == npat - 1) d = 9'(mask);
          else d = 9'((k * 37 + lc * 11 + pi * 5) & mask);
          frame_and_check(3'(lc), pm, d, pm[1] && (k % 5 == 3), (k % 7 == 4), -1);
        end
      end
    end

    // R2: codes above 4 select 9 bits
    frame_and_check(3'd7, 2'b11, 9'h1A5, 1'b0, 1'b0, -1);
    // R3: parity mode 01 means no parity slot
    frame_and_check(3'd3, 2'b01, 9'h0C3, 1'b0, 1'b0, -1);
    // R8: one-clock spike inside data bit 3
    frame_and_check(3'd3, 2'b10, 9'h000, 1'b0, 1'b0, 3);
    frame_and_check(3'd3, 2'b11, 9'h0FF, 1'b0, 1'b0, 5);

    // R6: back-to-back frames with a single stop bit, read mid stop
    cfg_len = 3'd3; cfg_parity = 2'b10;
    send_frame(8, 2'b10, 9'h05A, 1'b0, 1'b0, -1, 1'b1);
    chk(rx_data === 9'h05A, "R6", "first of pair", rx_data, 9'h05A);
    rd_strobe = 1'b1; wait_clk(1); rd_strobe = 1'b0;
    send_frame(8, 2'b10, 9'h0A7, 1'b0, 1'b0, -1, 1'b1);
    wait_clk(4);
    chk(rx_data === 9'h0A7, "R6", "second of pair", rx_data, 9'h0A7);
    chk(parity_err === 1'b0, "R6", "second of pair parity", parity_err, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule